// File: doc/BRIEF.md
# Streaming Radix-2 Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor. The two operands arrive on separate AXI4-Stream-style channels, each with its own tlast and tuser sideband. A pair is taken only when both channels present data on the same clock and the divider has nothing in flight. The quotient is produced by a restoring shift-subtract loop. The loop retires several quotient bits per clock, so that a whole division fits in `DIV_CLOCKS` clocks.

The result leaves on one output channel. Its tdata holds the quotient together with either the integer remainder or a binary fraction that extends the quotient. The output tuser joins both input tuser fields and adds a divide-by-zero flag. The output tlast follows one of four rules picked at runtime. A result stays on the output until downstream takes it. A clock enable freezes the whole block, and the synchronous active-low reset overrides the clock enable.

Top module: `stream_divider`

## Requirements
- R1: A pair is accepted only on a clock where `ce` is high, both `s_dvd_tvalid` and `s_dvs_tvalid` are high, the engine is idle and no result is waiting. `s_dvd_tready` and `s_dvs_tready` are asserted together on exactly that clock. With only one channel valid, neither tready rises.
- R2: With `frac_mode`=0, `m_res_tdata[7:0]` holds the remainder (divisor width 8, padded to one byte). `m_res_tdata[23:8]` holds the quotient, dividend / divisor, which is as wide as the dividend. Unused bits are zero.
- R3: With `frac_mode`=1, `m_res_tdata[23:8]` holds the quotient and `m_res_tdata[7:0]` holds the fraction floor((dividend mod divisor)·2^8 / divisor).
- R4: A zero divisor sets `m_res_tuser[0]`, forces the quotient field to all ones, and forces the remainder or fraction field to zero.
- R5: `m_res_tuser` is {dividend tuser, divisor tuser, zero flag}, from MSB to LSB.
- R6: `m_res_tlast` follows the rule code sampled at acceptance: 0 = dividend tlast, 1 = divisor tlast, 2 = OR of both, 3 = AND of both.
- R7: A result stays on the output, with tvalid high and data, tuser and tlast unchanged, until it is taken. While it waits, no new pair is accepted.
- R8: While `ce` is low, no pair is accepted, no result is handed over and a running division does not advance.
- R9: When `rst_n` is held low for at least two clocks, `m_res_tvalid` goes low and any division in progress is discarded, whatever the level of `ce`.
- R10: With `ce` high, `m_res_tvalid` rises no more than `DIV_CLOCKS` clocks after the accepting clock.
- R11: The mode and tlast rule are taken from the accepting clock. Changing them during a division does not alter that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable |
| s_dvd_tdata | input | DW | Dividend |
| s_dvd_tvalid | input | 1 | Dividend valid |
| s_dvd_tready | output | 1 | Dividend taken |
| s_dvd_tlast | input | 1 | Dividend tlast |
| s_dvd_tuser | input | UA_W | Dividend sideband |
| s_dvs_tdata | input | DSW | Divisor |
| s_dvs_tvalid | input | 1 | Divisor valid |
| s_dvs_tready | output | 1 | Divisor taken |
| s_dvs_tlast | input | 1 | Divisor tlast |
| s_dvs_tuser | input | UB_W | Divisor sideband |
| frac_mode | input | 1 | 0 = integer remainder, 1 = fraction |
| last_rule | input | 2 | Output tlast rule code |
| m_res_tdata | output | OUT_W | Packed quotient and remainder or fraction |
| m_res_tvalid | output | 1 | Result valid |
| m_res_tready | input | 1 | Downstream ready |
| m_res_tlast | output | 1 | Result tlast |
| m_res_tuser | output | UA_W+UB_W+1 | Joined sideband and zero flag |

## Verification
A corrupted partial remainder or a wrong step count shows up in the first result that follows, as a wrong quotient, remainder or fraction. A count that never reaches zero instead leaves tvalid low past the `DIV_CLOCKS` bound. Sideband latched on the wrong clock gives a wrong tuser or tlast on that same result, and the mode-change test makes this visible. A stuck pending flag appears as a tready that never rises, or as a second result handed over before the first has been taken. These faults are caught within a few clocks of the transfer concerned.

// File: rtl/sdiv_pkg.sv
// Shared types and helpers for the streaming divider.
// Assumes: widths passed to byte_pad are positive.
package sdiv_pkg;

    // Output tlast derivation rule, code fixed by the port contract.
    typedef enum logic [1:0] {
        LAST_FROM_DVD = 2'd0,
        LAST_FROM_DVS = 2'd1,
        LAST_EITHER   = 2'd2,
        LAST_BOTH     = 2'd3
    } last_rule_e;

    // Round a field width up to a whole number of bytes.
    function automatic int byte_pad(input int w);
        return ((w + 7) / 8) * 8;
    endfunction

    // Larger of two widths.
    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Combine the two input tlast bits according to a rule.
    function automatic logic pick_last(input last_rule_e rule, input logic la, input logic lb);
        case (rule)
            LAST_FROM_DVD: return la;
            LAST_FROM_DVS: return lb;
            LAST_EITHER:   return la | lb;
            default:       return la & lb;
        endcase
    endfunction

endpackage

// File: rtl/sdiv_accept.sv
// Operand join: decides when a dividend/divisor pair is taken and
// latches the sideband (tuser, tlast, mode, rule, zero divisor) for
// the result. Assumes srst_n is the internally registered reset.
module sdiv_accept
    import sdiv_pkg::*;
#(
    parameter int UA_W = 2,
    parameter int UB_W = 2,
    parameter int DSW  = 8
) (
    input  logic            clk,
    input  logic            srst_n,
    input  logic            ce,
    input  logic            engine_idle,
    input  logic            result_pending,
    input  logic            a_valid,
    input  logic            b_valid,
    input  logic [UA_W-1:0] a_user,
    input  logic [UB_W-1:0] b_user,
    input  logic            a_last,
    input  logic            b_last,
    input  logic [DSW-1:0]  divisor,
    input  logic            frac_in,
    input  last_rule_e      rule_in,
    output logic            fire,
    output logic [UA_W-1:0] a_user_q,
    output logic [UB_W-1:0] b_user_q,
    output logic            a_last_q,
    output logic            b_last_q,
    output logic            zero_q,
    output logic            frac_q,
    output last_rule_e      rule_q
);

    // Accept when enabled, out of reset, idle, nothing waiting, both valid.
    assign fire = ce && srst_n && engine_idle && !result_pending && a_valid && b_valid;

    // Capture the sideband of the accepted pair.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            a_user_q <= '0;
            b_user_q <= '0;
            a_last_q <= 1'b0;
            b_last_q <= 1'b0;
            zero_q   <= 1'b0;
            frac_q   <= 1'b0;
            rule_q   <= LAST_FROM_DVD;
        end else if (fire) begin
            a_user_q <= a_user;
            b_user_q <= b_user;
            a_last_q <= a_last;
            b_last_q <= b_last;
            zero_q   <= (divisor == '0);
            frac_q   <= frac_in;
            rule_q   <= rule_in;
        end
    end

    // R7: never take a pair while a result waits at the output
    p_no_take_pending_r7: assert property (@(posedge clk) disable iff (!srst_n)
        result_pending |-> !fire);

endmodule

// File: rtl/sdiv_engine.sv
// Restoring radix-2 shift-subtract engine. Retires STEPS_PER_CLK
// quotient bits per enabled clock, DW bits in remainder mode and
// DW+FW bits in fraction mode (zeros shifted in after the dividend).
// Assumes DW >= 2 and that load is only raised while idle.
module sdiv_engine #(
    parameter int DW         = 16,
    parameter int DSW        = 8,
    parameter int FW         = 8,
    parameter int DIV_CLOCKS = 4
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             ce,
    input  logic             load,
    input  logic             load_frac,
    input  logic [DW-1:0]    dividend,
    input  logic [DSW-1:0]   divisor,
    output logic             busy,
    output logic             done,
    output logic [DW+FW-1:0] quot_acc,
    output logic [DSW-1:0]   part_rem
);

    localparam int AW            = DW + FW;
    localparam int MAX_STEPS     = DW + FW;
    localparam int STEPS_PER_CLK = (MAX_STEPS + DIV_CLOCKS - 1) / DIV_CLOCKS;
    localparam int CNT_W         = $clog2(MAX_STEPS + 1);
    localparam int LEN_W         = $clog2(DIV_CLOCKS + 2);

    logic [DSW:0]   rem_r;
    logic [DSW-1:0] div_r;
    logic [DW-1:0]  shin_r;
    logic [AW-1:0]  acc_r;
    logic [CNT_W-1:0] cnt_r;
    logic           busy_r;

    logic [DSW:0]  r_s [0:STEPS_PER_CLK];
    logic [DW-1:0] s_s [0:STEPS_PER_CLK];
    logic [AW-1:0] a_s [0:STEPS_PER_CLK];

    assign r_s[0] = rem_r;
    assign s_s[0] = shin_r;
    assign a_s[0] = acc_r;

    // Unrolled shift-subtract stages; a stage past the remaining count passes through.
    for (genvar j = 0; j < STEPS_PER_CLK; j++) begin : g_step
        logic         act;
        logic [DSW:0] trial;
        logic         ge;
        assign act   = cnt_r > CNT_W'(j);
        assign trial = {r_s[j][DSW-1:0], s_s[j][DW-1]};
        assign ge    = (trial >= {1'b0, div_r});
        assign r_s[j+1] = !act ? r_s[j] : (ge ? trial - {1'b0, div_r} : trial);
        assign s_s[j+1] = act ? {s_s[j][DW-2:0], 1'b0} : s_s[j];
        assign a_s[j+1] = act ? {a_s[j][AW-2:0], ge} : a_s[j];
    end

    // Final clock of a division: the remaining steps fit in this clock.
    assign done     = busy_r && ce && (cnt_r <= CNT_W'(STEPS_PER_CLK));
    assign busy     = busy_r;
    assign quot_acc = a_s[STEPS_PER_CLK];
    assign part_rem = r_s[STEPS_PER_CLK][DSW-1:0];

    // Load operands or advance the iteration by one clock's worth of steps.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            busy_r <= 1'b0;
            cnt_r  <= '0;
            rem_r  <= '0;
            div_r  <= '0;
            shin_r <= '0;
            acc_r  <= '0;
        end else if (ce) begin
            if (load) begin
                busy_r <= 1'b1;
                cnt_r  <= load_frac ? CNT_W'(DW + FW) : CNT_W'(DW);
                rem_r  <= '0;
                div_r  <= divisor;
                shin_r <= dividend;
                acc_r  <= '0;
            end else if (busy_r) begin
                busy_r <= !done;
                cnt_r  <= done ? '0 : cnt_r - CNT_W'(STEPS_PER_CLK);
                rem_r  <= r_s[STEPS_PER_CLK];
                shin_r <= s_s[STEPS_PER_CLK];
                acc_r  <= a_s[STEPS_PER_CLK];
            end
        end
    end

    // Checker: busy clocks spent on the current division.
    logic [LEN_W-1:0] busy_len;
    always_ff @(posedge clk) begin
        if (!srst_n)                busy_len <= '0;
        else if (ce && load)        busy_len <= '0;
        else if (ce && busy_r)      busy_len <= busy_len + 1'b1;
    end

    // R10: a division never needs more than DIV_CLOCKS enabled clocks
    p_latency_bound_r10: assert property (@(posedge clk) disable iff (!srst_n)
        busy_r |-> busy_len < LEN_W'(DIV_CLOCKS));

    // R8: with the enable low the iteration holds still
    p_ce_freeze_r8: assert property (@(posedge clk) disable iff (!srst_n)
        (!ce && busy_r) |=> (busy_r && $stable(cnt_r) && $stable(acc_r)));

endmodule

// File: rtl/sdiv_emit.sv
// Result stage: packs quotient with remainder (byte-padded fields) or
// fraction (one padded field), forces the zero-divisor pattern, joins
// the sideband, and holds the result until downstream takes it.
// Assumes done is never raised while a result is held.
module sdiv_emit
    import sdiv_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DSW   = 8,
    parameter int FW    = 8,
    parameter int UA_W  = 2,
    parameter int UB_W  = 2,
    parameter int OUT_W = 24
) (
    input  logic                 clk,
    input  logic                 srst_n,
    input  logic                 ce,
    input  logic                 done,
    input  logic [DW+FW-1:0]     quot_acc,
    input  logic [DSW-1:0]       part_rem,
    input  logic [UA_W-1:0]      a_user_q,
    input  logic [UB_W-1:0]      b_user_q,
    input  logic                 a_last_q,
    input  logic                 b_last_q,
    input  logic                 zero_q,
    input  logic                 frac_q,
    input  last_rule_e           rule_q,
    input  logic                 m_ready,
    output logic                 m_valid,
    output logic [OUT_W-1:0]     m_data,
    output logic [UA_W+UB_W:0]   m_user,
    output logic                 m_last
);

    localparam int R_PAD = byte_pad(DSW);

    logic [OUT_W-1:0] packed_w;

    // Lay out the result fields for the latched mode.
    always_comb begin
        packed_w = '0;
        if (frac_q) begin
            packed_w[DW+FW-1:0] = zero_q ? {{DW{1'b1}}, {FW{1'b0}}} : quot_acc;
        end else begin
            packed_w[R_PAD +: DW] = zero_q ? {DW{1'b1}} : quot_acc[DW-1:0];
            packed_w[DSW-1:0]     = zero_q ? '0 : part_rem;
        end
    end

    // Hold register: load on completion, release on an enabled handshake.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            m_valid <= 1'b0;
            m_data  <= '0;
            m_user  <= '0;
            m_last  <= 1'b0;
        end else if (ce) begin
            if (done) begin
                m_valid <= 1'b1;
                m_data  <= packed_w;
                m_user  <= {a_user_q, b_user_q, zero_q};
                m_last  <= pick_last(rule_q, a_last_q, b_last_q);
            end else if (m_valid && m_ready) begin
                m_valid <= 1'b0;
            end
        end
    end

    // R7: an untaken result keeps every field
    p_hold_result_r7: assert property (@(posedge clk) disable iff (!srst_n)
        (m_valid && !(m_ready && ce)) |=>
            (m_valid && $stable(m_data) && $stable(m_user) && $stable(m_last)));

    // R4: a zero divisor finishes with the flag set
    p_zero_flag_r4: assert property (@(posedge clk) disable iff (!srst_n)
        (done && zero_q) |=> (m_valid && m_user[0]));

endmodule

// File: rtl/stream_divider.sv
// Streaming radix-2 unsigned divider top. Joins two operand streams,
// runs the iterative engine and emits one packed result stream.
// Assumes rst_n is held low for at least two clocks; the reset is
// registered once before it reaches the datapath and ignores ce.
module stream_divider
    import sdiv_pkg::*;
#(
    parameter int DW         = 16,
    parameter int DSW        = 8,
    parameter int FW         = 8,
    parameter int UA_W       = 2,
    parameter int UB_W       = 2,
    parameter int DIV_CLOCKS = 4,
    localparam int OUT_W     = max_w(byte_pad(DW) + byte_pad(DSW), byte_pad(DW + FW))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce,
    input  logic [DW-1:0]      s_dvd_tdata,
    input  logic               s_dvd_tvalid,
    output logic               s_dvd_tready,
    input  logic               s_dvd_tlast,
    input  logic [UA_W-1:0]    s_dvd_tuser,
    input  logic [DSW-1:0]     s_dvs_tdata,
    input  logic               s_dvs_tvalid,
    output logic               s_dvs_tready,
    input  logic               s_dvs_tlast,
    input  logic [UB_W-1:0]    s_dvs_tuser,
    input  logic               frac_mode,
    input  logic [1:0]         last_rule,
    output logic [OUT_W-1:0]   m_res_tdata,
    output logic               m_res_tvalid,
    input  logic               m_res_tready,
    output logic               m_res_tlast,
    output logic [UA_W+UB_W:0] m_res_tuser
);

    logic srst_n;
    logic fire;
    logic busy;
    logic done;
    logic [DW+FW-1:0] quot_acc;
    logic [DSW-1:0]   part_rem;
    logic [UA_W-1:0]  a_user_q;
    logic [UB_W-1:0]  b_user_q;
    logic a_last_q, b_last_q, zero_q, frac_q;
    last_rule_e rule_q;

    // Register the external reset once before the datapath sees it.
    always_ff @(posedge clk) begin
        srst_n <= rst_n;
    end

    assign s_dvd_tready = fire;
    assign s_dvs_tready = fire;

    sdiv_accept #(.UA_W(UA_W), .UB_W(UB_W), .DSW(DSW)) u_accept (
        .clk(clk), .srst_n(srst_n), .ce(ce),
        .engine_idle(!busy), .result_pending(m_res_tvalid),
        .a_valid(s_dvd_tvalid), .b_valid(s_dvs_tvalid),
        .a_user(s_dvd_tuser), .b_user(s_dvs_tuser),
        .a_last(s_dvd_tlast), .b_last(s_dvs_tlast),
        .divisor(s_dvs_tdata), .frac_in(frac_mode),
        .rule_in(last_rule_e'(last_rule)),
        .fire(fire),
        .a_user_q(a_user_q), .b_user_q(b_user_q),
        .a_last_q(a_last_q), .b_last_q(b_last_q),
        .zero_q(zero_q), .frac_q(frac_q), .rule_q(rule_q)
    );

    sdiv_engine #(.DW(DW), .DSW(DSW), .FW(FW), .DIV_CLOCKS(DIV_CLOCKS)) u_engine (
        .clk(clk), .srst_n(srst_n), .ce(ce),
        .load(fire), .load_frac(frac_mode),
        .dividend(s_dvd_tdata), .divisor(s_dvs_tdata),
        .busy(busy), .done(done),
        .quot_acc(quot_acc), .part_rem(part_rem)
    );

    sdiv_emit #(.DW(DW), .DSW(DSW), .FW(FW), .UA_W(UA_W), .UB_W(UB_W), .OUT_W(OUT_W)) u_emit (
        .clk(clk), .srst_n(srst_n), .ce(ce),
        .done(done), .quot_acc(quot_acc), .part_rem(part_rem),
        .a_user_q(a_user_q), .b_user_q(b_user_q),
        .a_last_q(a_last_q), .b_last_q(b_last_q),
        .zero_q(zero_q), .frac_q(frac_q), .rule_q(rule_q),
        .m_ready(m_res_tready),
        .m_valid(m_res_tvalid), .m_data(m_res_tdata),
        .m_user(m_res_tuser), .m_last(m_res_tlast)
    );

    // R1: a pair is only taken while the output is empty and the engine idle
    p_take_when_free_r1: assert property (@(posedge clk) disable iff (!srst_n)
        s_dvd_tready |-> (!m_res_tvalid && !busy && s_dvs_tvalid));

    // R9: a registered reset clears the output on the following clock
    p_reset_clears_r9: assert property (@(posedge clk)
        (!srst_n && !$isunknown(srst_n)) |=> !m_res_tvalid);

endmodule

// File: tb/stream_divider_tb.sv
// Scoreboard bench: send tasks queue expected results, a monitor
// pops and compares them at each output handshake.
module stream_divider_tb;

    localparam int DW = 16, DSW = 8, FW = 8, UA_W = 2, UB_W = 2, DIV_CLOCKS = 4;
    localparam int OUT_W = 24;
    localparam int US_W = UA_W + UB_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b1;
    logic [DW-1:0] dvd = '0;
    logic dvd_v = 1'b0, dvd_l = 1'b0;
    logic [UA_W-1:0] dvd_u = '0;
    logic [DSW-1:0] dvs = '0;
    logic dvs_v = 1'b0, dvs_l = 1'b0;
    logic [UB_W-1:0] dvs_u = '0;
    logic fmode = 1'b0;
    logic [1:0] rule = 2'd0;
    logic rdy = 1'b0;
    logic dvd_r, dvs_r, res_v, res_l;
    logic [OUT_W-1:0] res_d;
    logic [US_W-1:0] res_u;

    int tests = 0, fails = 0;
    int rdy_mode = 0;
    logic [OUT_W+US_W:0] exp_q[$];
    string tag_q[$];
    logic prev_pend = 1'b0;
    logic [OUT_W-1:0] prev_d;

    always #2 clk = ~clk;

    stream_divider #(.DW(DW), .DSW(DSW), .FW(FW), .UA_W(UA_W), .UB_W(UB_W),
                     .DIV_CLOCKS(DIV_CLOCKS)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .s_dvd_tdata(dvd), .s_dvd_tvalid(dvd_v), .s_dvd_tready(dvd_r),
        .s_dvd_tlast(dvd_l), .s_dvd_tuser(dvd_u),
        .s_dvs_tdata(dvs), .s_dvs_tvalid(dvs_v), .s_dvs_tready(dvs_r),
        .s_dvs_tlast(dvs_l), .s_dvs_tuser(dvs_u),
        .frac_mode(fmode), .last_rule(rule),
        .m_res_tdata(res_d), .m_res_tvalid(res_v), .m_res_tready(rdy),
        .m_res_tlast(res_l), .m_res_tuser(res_u)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected packed data per R2, R3, R4.
    function automatic logic [OUT_W-1:0] exp_data(input logic [DW-1:0] a,
                                                  input logic [DSW-1:0] b, input logic fm);
        logic [DW-1:0] q;
        logic [DSW-1:0] r;
        logic [31:0] f;
        if (b == 0) return {{DW{1'b1}}, 8'h00};
        q = a / b;
        r = DSW'(a % b);
        f = ({24'd0, r} << FW) / {24'd0, b};
        return fm ? {q, f[FW-1:0]} : {q, r};
    endfunction

    // Expected tlast per R6.
    function automatic logic exp_last(input logic [1:0] rl, input logic la, input logic lb);
        case (rl)
            2'd0: return la;
            2'd1: return lb;
            2'd2: return la | lb;
            default: return la & lb;
        endcase
    endfunction

    // Downstream ready pattern.
    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0: rdy = 1'b1;
            1: rdy = ($urandom_range(0, 2) != 0);
            default: rdy = 1'b0;
        endcase
    end

    // Monitor: compare each handed-over result with the queue head (R2..R6, R11).
    always @(negedge clk) begin
        if (rst_n && u_dut.srst_n) begin
            if (prev_pend && res_v)
                check(res_d == prev_d, "R7", "held data changed", 64'(res_d), 64'(prev_d));
            if (res_v && rdy && ce) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected result", 64'(res_d), 64'd0);
                end else begin
                    logic [OUT_W+US_W:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(res_d == e[OUT_W+US_W:US_W+1], t, "tdata",
                          64'(res_d), 64'(e[OUT_W+US_W:US_W+1]));
                    check(res_u == e[US_W:1], t, "tuser", 64'(res_u), 64'(e[US_W:1]));
                    check(res_l == e[0], t, "tlast", 64'(res_l), 64'(e[0]));
                end
            end
            prev_pend = res_v && !(rdy && ce);
            prev_d = res_d;
        end else begin
            prev_pend = 1'b0;
        end
    end

    // Present a pair and queue its expectation.
    task automatic send_start(input logic [DW-1:0] a, input logic [DSW-1:0] b,
                              input logic [UA_W-1:0] ua, input logic [UB_W-1:0] ub,
                              input logic la, input logic lb, input logic fm,
                              input logic [1:0] rl, input string tag);
        @(posedge clk); #1;
        dvd = a; dvs = b; dvd_u = ua; dvs_u = ub; dvd_l = la; dvs_l = lb;
        fmode = fm; rule = rl; dvd_v = 1'b1; dvs_v = 1'b1;
        exp_q.push_back({exp_data(a, b, fm), ua, ub, (b == 0), exp_last(rl, la, lb)});
        tag_q.push_back(tag);
    endtask

    // Wait for acceptance, checking that both treadys rise together (R1).
    task automatic send_wait();
        forever begin
            @(negedge clk);
            if (dvd_r || dvs_r) begin
                check(dvd_r == dvs_r, "R1", "treadys differ", 64'(dvd_r), 64'(dvs_r));
                break;
            end
        end
        @(posedge clk); #1;
        dvd_v = 1'b0; dvs_v = 1'b0;
    endtask

    task automatic send(input logic [DW-1:0] a, input logic [DSW-1:0] b,
                        input logic [UA_W-1:0] ua, input logic [UB_W-1:0] ub,
                        input logic la, input logic lb, input logic fm,
                        input logic [1:0] rl, input string tag);
        send_start(a, b, ua, ub, la, lb, fm, rl, tag);
        send_wait();
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R7", "results outstanding", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rdy_mode = 0;
        wait_cycles(4);
        // R9: reset state
        @(negedge clk);
        check(res_v == 1'b0, "R9", "tvalid in reset", 64'(res_v), 64'd0);
        @(posedge clk); #1 rst_n = 1'b1;
        wait_cycles(2);

        // R1: one channel valid alone is never taken
        dvd_v = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!dvd_r && !dvs_r, "R1", "tready with one valid", 64'(dvd_r), 64'd0);
        end
        @(posedge clk); #1 dvd_v = 1'b0;
        dvs_v = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!dvd_r && !dvs_r, "R1", "tready with divisor only", 64'(dvs_r), 64'd0);
        end
        @(posedge clk); #1 dvs_v = 1'b0;

        // R2: remainder mode, R5 sideband
        send(16'd1000, 8'd7, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, "R2");
        send(16'd5, 8'd9, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, "R2");
        send(16'hFFFF, 8'd1, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, "R5");
        send(16'hFFFF, 8'd255, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, "R2");
        send(16'd0, 8'd3, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, "R2");
        // R3: fraction mode
        send(16'd10, 8'd4, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, "R3");
        send(16'd1, 8'd3, 2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0, "R3");
        send(16'd40000, 8'd200, 2'd3, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, "R3");
        // R4: divide by zero, both modes
        send(16'd1234, 8'd0, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, "R4");
        send(16'd77, 8'd0, 2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, "R4");
        drain();

        // R6: every rule against every tlast pair, with random back-pressure
        rdy_mode = 1;
        for (int rl = 0; rl < 4; rl++)
            for (int lc = 0; lc < 4; lc++)
                send(16'(100 + rl * 37 + lc), 8'(3 + lc), 2'(rl), 2'(lc),
                     lc[0], lc[1], rl[0], 2'(rl), "R6");
        drain();

        // R7: result held, and no new pair taken while it waits
        rdy_mode = 2;
        send(16'd900, 8'd11, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 2'd2, "R7");
        wait_cycles(DIV_CLOCKS + 3);
        @(negedge clk);
        check(res_v == 1'b1, "R7", "result not waiting", 64'(res_v), 64'd1);
        send_start(16'd64, 8'd8, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 2'd1, "R7");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!dvd_r, "R7", "pair taken while pending", 64'(dvd_r), 64'd0);
        end
        rdy_mode = 0;
        send_wait();
        drain();

        // R8: enable low pauses the division and blocks hand-over
        rdy_mode = 2;
        send(16'd3000, 8'd13, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, "R8");
        ce = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(res_v == 1'b0, "R8", "advanced with ce low", 64'(res_v), 64'd0);
        end
        @(posedge clk); #1 ce = 1'b1;
        wait_cycles(DIV_CLOCKS + 2);
        rdy_mode = 0;
        ce = 1'b0;
        dvd_v = 1'b1; dvs_v = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(res_v == 1'b1, "R8", "taken with ce low", 64'(res_v), 64'd1);
            check(!dvd_r, "R8", "pair taken with ce low", 64'(dvd_r), 64'd0);
        end
        @(posedge clk); #1;
        dvd_v = 1'b0; dvs_v = 1'b0;
        ce = 1'b1;
        drain();

        // R10: latency bound, both modes
        for (int m = 0; m < 2; m++) begin
            int n;
            send(16'd5555, 8'd21, 2'd0, 2'd0, 1'b0, 1'b0, m[0], 2'd0, "R10");
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!res_v && n < 20);
            check(n >= 2 && n <= DIV_CLOCKS + 1, "R10", "clocks to result",
                  64'(n), 64'(DIV_CLOCKS + 1));
        end
        drain();

        // R11: mode and rule changed during the division do not matter
        rdy_mode = 1;
        send(16'd777, 8'd10, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1, 2'd3, "R11");
        fmode = 1'b0; rule = 2'd0;
        wait_cycles(2);
        send(16'd777, 8'd10, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 2'd2, "R11");
        fmode = 1'b1; rule = 2'd3;
        drain();

        // R9: reset with ce low discards a running division
        rdy_mode = 0;
        send(16'd4321, 8'd5, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, "R9");
        ce = 1'b0;
        rst_n = 1'b0;
        wait_cycles(3);
        @(negedge clk);
        check(res_v == 1'b0, "R9", "tvalid during reset", 64'(res_v), 64'd0);
        exp_q.delete();
        tag_q.delete();
        rst_n = 1'b1;
        ce = 1'b1;
        for (int i = 0; i < DIV_CLOCKS + 4; i++) begin
            @(negedge clk);
            check(res_v == 1'b0, "R9", "stale result after reset", 64'(res_v), 64'd0);
        end
        send(16'd50, 8'd6, 2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 2'd3, "R9");
        drain();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule